// File: doc/BRIEF.md
# Write-Protected Sweep Pattern Table

This block holds the voltage pattern that a detector sweep sequencer steps through. The pattern is 256 words of 16 bits, 512 bytes in all. The command register path is the only writer and loads the words one at a time. The sweep sequencer is the only reader and fetches one word per step. A single storage array serves both. Each cycle it takes its address either from the loader side or from the sequencer side.

While the sweep subsystem is running, the sweep-enable input is high and the table is write-protected. A write attempted in that state changes nothing. It sets a status flag that stays high until the next reset, so a controller can later see that a load was refused. When a read and a write arrive in the same cycle, the read takes the array and the write is dropped. Read data is registered and comes with a valid pulse one clock after the read strobe.

Top module: `pattern_table`

## Requirements
- R1: When `ld_stb` is high, `seq_stb` is low and `sweep_on` is low at a rising clock edge, the word on `ld_data` is stored at address `ld_addr`.
- R2: When `seq_stb` is high at a rising edge, `seq_data` shows the word stored at `seq_addr` from that edge on. `seq_valid` is high for exactly the cycle after each strobed cycle. Without a strobe, `seq_data` keeps its last value.
- R3: While `sweep_on` is high, a load strobe leaves every stored word unchanged. Reads are still served.
- R4: When `ld_stb` and `seq_stb` are both high in one cycle, the read is served from the contents as they were before that edge, and the write is discarded.
- R5: `ld_blocked` goes high at the edge where `ld_stb` and `sweep_on` are both sampled high, and stays high until reset. It is not set by normal writes or by a write dropped only because of a read collision.
- R6: While `rst_n` is low and after its release, `seq_data` is 0, `seq_valid` is 0 and `ld_blocked` is 0, until the first strobe.
- R7: All 256 addresses, 0 through 255, hold separate words.
- R8: A read strobed in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sweep_on | input | 1 | Sweep subsystem active; write-protects the table |
| ld_addr | input | 8 | Loader word address |
| ld_data | input | 16 | Loader write word |
| ld_stb | input | 1 | Loader write strobe |
| seq_addr | input | 8 | Sequencer word address |
| seq_stb | input | 1 | Sequencer read strobe |
| seq_data | output | 16 | Registered read word |
| seq_valid | output | 1 | High one cycle after a read strobe |
| ld_blocked | output | 1 | Sticky flag: a write was refused under sweep |

## Verification
A wrong address select or a write enable that leaks under sweep leaves a corrupted word in the array. That word shows up on `seq_data` only at the first later read of the affected address. The bench therefore reads back every word it has guarded, both after each protected or colliding write and across the full address range. A bad read pipeline shows on `seq_valid` and `seq_data` one edge after the strobe. A bad flag shows on `ld_blocked` one edge after the refused write and in every cycle after that.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;

   // operation granted to the shared array in one cycle
   typedef enum logic [1:0] {
      PT_IDLE  = 2'd0,
      PT_LOAD  = 2'd1,
      PT_FETCH = 2'd2,
      PT_DROP  = 2'd3
   } pt_op_e;

   function automatic bit pt_is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/pt_port_arbiter.sv
`timescale 1ns/1ps
module pt_port_arbiter
   import pt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              sweep_on,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              seq_stb,
   input  logic [ADDR_W-1:0] seq_addr,
   output pt_op_e            op,
   output logic [ADDR_W-1:0] arr_addr,
   output logic              guard_hit
);

   // sequencer first, then loader if the table is not protected
   always_comb begin
      if (seq_stb) begin
         op       = PT_FETCH;
         arr_addr = seq_addr;
      end else if (ld_stb) begin
         op       = sweep_on ? PT_DROP : PT_LOAD;
         arr_addr = ld_addr;
      end else begin
         op       = PT_IDLE;
         arr_addr = seq_addr;
      end
   end

   // a load attempt under sweep, whether or not a read also came
   assign guard_hit = ld_stb & sweep_on;

endmodule

// File: rtl/pt_storage_array.sv
`timescale 1ns/1ps
module pt_storage_array
   import pt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 256,
   parameter int ADDR_W      = 8,
   parameter bit CLEAR_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pt_op_e            op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              we,
   output logic              re
);

   logic [DATA_W-1:0] words [DEPTH];

   assign we = (op == PT_LOAD);
   assign re = (op == PT_FETCH);

   always_ff @(posedge clk) begin
      if (we) begin
         words[addr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
      end else begin
         rvalid <= re;
      end
   end

   generate
      if (CLEAR_RDATA) begin : g_rd_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else if (re) begin
               rdata <= words[addr];
            end
         end
      end else begin : g_rd_plain
         always_ff @(posedge clk) begin
            if (re) begin
               rdata <= words[addr];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pt_guard_flag.sv
`timescale 1ns/1ps
module pt_guard_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;
      end
   end

endmodule

// File: rtl/pattern_table.sv
`timescale 1ns/1ps
module pattern_table
   import pt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 256,
   parameter bit CLEAR_RDATA = 1'b1,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sweep_on,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic              seq_stb,
   output logic [DATA_W-1:0] seq_data,
   output logic              seq_valid,
   output logic              ld_blocked
);

   generate
      if (!pt_is_pow2(DEPTH)) begin : g_bad_depth
         $error("pattern_table: DEPTH must be a power of two above 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("pattern_table: DATA_W must be at least 1");
      end
   endgenerate

   pt_op_e            op;
   logic [ADDR_W-1:0] arr_addr;
   logic              guard_hit;
   logic              arr_we;
   logic              arr_re;

   pt_port_arbiter #(
      .ADDR_W (ADDR_W)
   ) u_arb (
      .sweep_on  (sweep_on),
      .ld_stb    (ld_stb),
      .ld_addr   (ld_addr),
      .seq_stb   (seq_stb),
      .seq_addr  (seq_addr),
      .op        (op),
      .arr_addr  (arr_addr),
      .guard_hit (guard_hit)
   );

   pt_storage_array #(
      .DATA_W      (DATA_W),
      .DEPTH       (DEPTH),
      .ADDR_W      (ADDR_W),
      .CLEAR_RDATA (CLEAR_RDATA)
   ) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .addr   (arr_addr),
      .wdata  (ld_data),
      .rdata  (seq_data),
      .rvalid (seq_valid),
      .we     (arr_we),
      .re     (arr_re)
   );

   pt_guard_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (guard_hit),
      .flag  (ld_blocked)
   );

endmodule

// File: rtl/pattern_table_chk.sv
`timescale 1ns/1ps
module pattern_table_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sweep_on,
   input logic              ld_stb,
   input logic              seq_stb,
   input logic [DATA_W-1:0] seq_data,
   input logic              seq_valid,
   input logic              ld_blocked,
   input logic              arr_we,
   input logic              arr_re
);

   // R2
   valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_stb |=> seq_valid);

   // R2
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_stb |=> !seq_valid);

   // R2
   data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_stb |=> $stable(seq_data));

   // R3
   no_write_under_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_on |-> !arr_we);

   // R4
   read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stb && ld_stb) |-> (arr_re && !arr_we));

   // R5
   flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb && sweep_on) |=> ld_blocked);

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_blocked |=> ld_blocked);

   // R5
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ld_blocked) |-> $past(ld_stb && sweep_on));

endmodule

bind pattern_table pattern_table_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sweep_on   (sweep_on),
   .ld_stb     (ld_stb),
   .seq_stb    (seq_stb),
   .seq_data   (seq_data),
   .seq_valid  (seq_valid),
   .ld_blocked (ld_blocked),
   .arr_we     (arr_we),
   .arr_re     (arr_re)
);

// File: tb/pattern_table_test.sv
`timescale 1ns/1ps
module pattern_table_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sweep_on = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic        ld_stb = 1'b0;
   logic [7:0]  seq_addr = '0;
   logic        seq_stb = 1'b0;
   logic [15:0] seq_data;
   logic        seq_valid;
   logic        ld_blocked;

   int          n_tests = 0;
   int          n_fail = 0;
   logic [15:0] model [256];

   always #2.5 clk = ~clk;

   pattern_table uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sweep_on   (sweep_on),
      .ld_addr    (ld_addr),
      .ld_data    (ld_data),
      .ld_stb     (ld_stb),
      .seq_addr   (seq_addr),
      .seq_stb    (seq_stb),
      .seq_data   (seq_data),
      .seq_valid  (seq_valid),
      .ld_blocked (ld_blocked)
   );

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // single write, inputs driven at the falling edge
   task automatic do_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      ld_addr = a; ld_data = d; ld_stb = 1'b1;
      @(negedge clk);
      ld_stb = 1'b0;
      if (!sweep_on) model[a] = d;
   endtask

   // single read, result sampled one falling edge after the strobe edge
   task automatic do_read(input logic [7:0] a, input string req);
      @(negedge clk);
      seq_addr = a; seq_stb = 1'b1;
      @(negedge clk);
      seq_stb = 1'b0;
      chk(req, "read valid", {15'd0, seq_valid}, 16'd1);
      chk(req, $sformatf("read word @%0d", a), seq_data, model[a]);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6", "data in reset", seq_data, 16'd0);
      chk("R6", "valid in reset", {15'd0, seq_valid}, 16'd0);
      chk("R6", "flag in reset", {15'd0, ld_blocked}, 16'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6", "data after release", seq_data, 16'd0);
      chk("R6", "flag after release", {15'd0, ld_blocked}, 16'd0);
   endtask

   task automatic t_fill_all;
      for (int a = 0; a < 256; a++) begin
         do_write(a[7:0], (a[15:0] * 16'h0101) ^ 16'hA5C3);
      end
      chk("R5", "flag after normal writes", {15'd0, ld_blocked}, 16'd0);
      for (int a = 255; a >= 0; a--) begin
         do_read(a[7:0], "R7");
      end
      do_write(8'd0, 16'hFFFF);
      do_write(8'd255, 16'h0001);
      do_read(8'd0, "R1");
      do_read(8'd255, "R1");
      do_read(8'd1, "R7");
      do_read(8'd254, "R7");
   endtask

   task automatic t_pipeline;
      // back-to-back strobes, each sampled one edge later
      @(negedge clk);
      seq_addr = 8'd3; seq_stb = 1'b1;
      for (int k = 4; k < 7; k++) begin
         @(negedge clk);
         chk("R2", "pipelined word", seq_data, model[k - 1]);
         chk("R2", "pipelined valid", {15'd0, seq_valid}, 16'd1);
         seq_addr = k[7:0];
      end
      @(negedge clk);
      seq_stb = 1'b0;
      chk("R2", "last pipelined word", seq_data, model[6]);
      seq_addr = 8'd9;
      @(negedge clk);
      chk("R2", "valid drops", {15'd0, seq_valid}, 16'd0);
      chk("R2", "data held", seq_data, model[6]);
      repeat (3) @(negedge clk);
      chk("R2", "data still held", seq_data, model[6]);
   endtask

   task automatic t_write_then_read;
      @(negedge clk);
      ld_addr = 8'd40; ld_data = 16'h5A5A; ld_stb = 1'b1;
      @(negedge clk);
      ld_stb = 1'b0; model[40] = 16'h5A5A;
      seq_addr = 8'd40; seq_stb = 1'b1;
      @(negedge clk);
      seq_stb = 1'b0;
      chk("R8", "read right after write", seq_data, 16'h5A5A);
   endtask

   task automatic t_collision;
      // same address: read sees the old word, write is lost
      @(negedge clk);
      ld_addr = 8'd10; ld_data = 16'hDEAD; ld_stb = 1'b1;
      seq_addr = 8'd10; seq_stb = 1'b1;
      @(negedge clk);
      ld_stb = 1'b0; seq_stb = 1'b0;
      chk("R4", "collision read old", seq_data, model[10]);
      chk("R5", "no flag on collision", {15'd0, ld_blocked}, 16'd0);
      do_read(8'd10, "R4");
      // different addresses
      @(negedge clk);
      ld_addr = 8'd20; ld_data = 16'hBEEF; ld_stb = 1'b1;
      seq_addr = 8'd30; seq_stb = 1'b1;
      @(negedge clk);
      ld_stb = 1'b0; seq_stb = 1'b0;
      chk("R4", "collision read other", seq_data, model[30]);
      do_read(8'd20, "R4");
   endtask

   task automatic t_protect;
      @(negedge clk);
      sweep_on = 1'b1;
      @(negedge clk);
      chk("R5", "flag before blocked write", {15'd0, ld_blocked}, 16'd0);
      do_write(8'd5, 16'h1234);
      chk("R5", "flag after blocked write", {15'd0, ld_blocked}, 16'd1);
      do_read(8'd5, "R3");
      do_write(8'd128, 16'h4321);
      do_read(8'd128, "R3");
      sweep_on = 1'b0;
      repeat (4) @(negedge clk);
      chk("R5", "flag sticky", {15'd0, ld_blocked}, 16'd1);
      do_read(8'd5, "R3");
      do_write(8'd6, 16'h0F0F);
      do_read(8'd6, "R1");
      rst_n = 1'b0;
      @(negedge clk);
      chk("R6", "flag cleared by reset", {15'd0, ld_blocked}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5", "flag stays clear", {15'd0, ld_blocked}, 16'd0);
   endtask

   initial begin
      t_reset();
      t_fill_all();
      t_pipeline();
      t_write_then_read();
      t_collision();
      t_protect();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule